// File: doc/BRIEF.md
# Receive Frame Slot Packer

The block sits behind a bit-level single-wire receiver. It takes the receiver's byte stream and its end-of-frame, CRC-error and overrun strobes. For each frame it writes one fixed slot of eight 32-bit words through a word-write memory port. The first seven words carry the payload, packed little-endian. The eighth word is a status word that holds the byte count and the frame's error flags. Slots are used in turn over `NBUF` buffers, and the write address wraps from the last slot back to the first.

Software sees three sticky flags: buffer full, CRC error and overrun. The flags stay set until the clear strobe is pulsed. An interrupt line reports buffer full while its enable is set. While a slot is being finished, which means zero-filling the unused payload words and then writing the status word, the receiver inputs are not accepted. Nothing is accepted while receive-to-memory mode is disabled.

An overrun that hits during the frame-end cycle is carried forward into the next frame's status. This lets software that falls behind still find the lost frame by scanning the status words.

Top module: `rx_slot_packer`

## Requirements
- R1: The write address is `{slot, word}`, with a 3-bit word index inside each slot. Every accepted frame advances the slot by one, wrapping from NBUF-1 to 0. After reset the first frame goes to slot 0.
- R2: Payload byte k of a frame (counting from 0) is written to word k/4, bits 8*(k%4)+7 down to 8*(k%4). Byte lanes and words after the last byte are written as zero. A byte sent in the frame-end cycle belongs to the frame. Each accepted frame produces exactly eight writes, and the status word (word 7) is the last of them.
- R3: Status word bits [23:16] hold the number of payload bytes stored. Bits [15:0] and [31:27] are zero.
- R4: A frame holds at most 28 payload bytes. Bytes beyond the 28th are dropped, and the stored count is 28.
- R5: A frame that ends with no error sets status bit 26 (buffer full). The full flag is then set in the following cycle.
- R6: A CRC error strobe in the frame-end cycle sets status bits 24 and 26 and sets the CRC error flag.
- R7: An overrun strobe before the frame-end cycle sets status bit 25 and leaves bit 26 clear. It sets the overrun flag and does not set the full flag.
- R8: An overrun strobe in the frame-end cycle sets bits 25 and 26 in that frame's status and in the next accepted frame's status.
- R9: A frame ending while the full flag is still set, with no clear in that cycle, sets status bit 25 and the overrun flag. The frame is still written to the next slot.
- R10: While the DMA-mode enable is low, bytes, frame ends and error strobes are ignored. No write occurs, and neither the flags nor the slot pointer change.
- R11: The interrupt output equals the full flag ANDed with the interrupt enable.
- R12: A clear strobe clears all three flags in the next cycle. A set caused by a frame ending in the same cycle takes precedence.
- R13: Reset clears all flags and raises no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | Receive-to-memory mode enable |
| irq_en_i | input | 1 | Buffer-full interrupt enable |
| clr_i | input | 1 | Flag clear strobe |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| frame_end_i | input | 1 | End-of-frame strobe |
| crc_err_i | input | 1 | CRC error, sampled with frame end |
| ovr_i | input | 1 | Receive overrun strobe |
| mem_we_o | output | 1 | Memory word write enable |
| mem_addr_o | output | $clog2(NBUF)+3 | Word address: slot and word index |
| mem_data_o | output | 32 | Write data |
| full_o | output | 1 | Buffer-full flag |
| crc_err_o | output | 1 | CRC error flag |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Interrupt |

## Verification
The bench checks frame lengths of 0, 28 and 31 bytes. A design that miscounts the zero-fill would leave stale words in the slot or issue a ninth write, and one that does not saturate would wrap the length field. The bench checks the frame-end byte arriving together with the end strobe, which a careless assembler drops. It sends a frame while the full flag is still set, to expose a design that skips the slot or misses the overrun. It sends an overrun in the frame-end cycle followed by an empty frame, to catch a design that does not carry bits 25 and 26 forward. It also disables the mode between frames, after which a design with a leaking pointer writes the next frame into the wrong slot. Finally it pulses a clear in the same cycle as a frame end, which a design with the wrong precedence answers with flags that are all zero.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int WORD_W    = 3;
  localparam int PAY_WORDS = 7;
  localparam int MAX_BYTES = 4 * PAY_WORDS;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int LEN_W     = 8;
  localparam int LEN_LSB   = 16;
  localparam int CRC_BIT   = 24;
  localparam int OVR_BIT   = 25;
  localparam int FULL_BIT  = 26;

  typedef enum logic {ST_FILL, ST_FLUSH} fill_state_e;
endpackage

// File: rtl/rsp_status.sv
module rsp_status
  import rsp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             frame_done_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             crc_err_i,
  input  logic             ovr_i,
  input  logic             clr_i,
  output logic [31:0]      status_o,
  output logic             full_o,
  output logic             crc_o,
  output logic             ovr_o
);
  logic ovr_seen_q, carry_q;
  logic full_q, crc_q, ovr_q;
  logic [31:0] status_q;
  logic busy_full, b_crc, b_ovr, b_full;

  assign busy_full = full_q && !clr_i;
  assign b_crc  = crc_err_i;
  assign b_ovr  = ovr_seen_q || ovr_i || busy_full || carry_q;
  assign b_full = crc_err_i || !ovr_seen_q || ovr_i || carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_seen_q <= 1'b0;
      carry_q    <= 1'b0;
      status_q   <= '0;
    end else if (frame_done_i) begin
      ovr_seen_q <= 1'b0;
      carry_q    <= ovr_i;
      status_q   <= '0;
      status_q[LEN_LSB +: LEN_W] <= len_i;
      status_q[CRC_BIT]  <= b_crc;
      status_q[OVR_BIT]  <= b_ovr;
      status_q[FULL_BIT] <= b_full;
    end else if (accept_i && ovr_i) begin
      ovr_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      crc_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= (full_q && !clr_i) || (frame_done_i && b_full);
      crc_q  <= (crc_q  && !clr_i) || (frame_done_i && b_crc);
      ovr_q  <= (ovr_q  && !clr_i) || (frame_done_i && b_ovr);
    end
  end

  assign status_o = status_q;
  assign full_o   = full_q;
  assign crc_o    = crc_q;
  assign ovr_o    = ovr_q;

  a_r6_crc_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i && crc_err_i |=> full_o && crc_o && status_o[CRC_BIT] && status_o[FULL_BIT]);
  a_r8_ovr_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i && ovr_i |=> status_o[OVR_BIT] && status_o[FULL_BIT] && ovr_o);
  a_r12_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !frame_done_i |=> !full_o && !crc_o && !ovr_o);
  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15:0] == 16'h0 && status_o[31:27] == 5'h0);
endmodule

// File: rtl/rsp_fill.sv
module rsp_fill
  import rsp_pkg::*;
#(
  parameter int NBUF   = 4,
  parameter int SLOT_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dma_en_i,
  input  logic                     byte_valid_i,
  input  logic [7:0]               byte_i,
  input  logic                     frame_end_i,
  input  logic [31:0]              status_i,
  output logic                     accept_o,
  output logic                     frame_done_o,
  output logic [LEN_W-1:0]         len_o,
  output logic                     mem_we_o,
  output logic [SLOT_W+WORD_W-1:0] mem_addr_o,
  output logic [31:0]              mem_data_o
);
  localparam int AW = SLOT_W + WORD_W;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NBUF - 1);
  localparam logic [WORD_W-1:0] STAT_IDX  = WORD_W'(PAY_WORDS);

  fill_state_e       st_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [WORD_W-1:0] widx_q;
  logic [SLOT_W-1:0] slot_q;
  logic [31:0]       wbuf_q, wbuf_ins;
  logic              take_byte, word_full;
  logic              we_q;
  logic [AW-1:0]     addr_q;
  logic [31:0]       data_q;

  assign accept_o     = dma_en_i && (st_q == ST_FILL);
  assign take_byte    = accept_o && byte_valid_i && (cnt_q < CNT_W'(MAX_BYTES));
  assign cnt_nx       = cnt_q + CNT_W'(take_byte);
  assign word_full    = take_byte && (cnt_q[1:0] == 2'd3);
  assign frame_done_o = accept_o && frame_end_i;
  assign len_o        = LEN_W'(cnt_nx);

  always_comb begin
    wbuf_ins = wbuf_q;
    if (take_byte) wbuf_ins[8*cnt_q[1:0] +: 8] = byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FILL;
      cnt_q  <= '0;
      widx_q <= '0;
      slot_q <= '0;
      wbuf_q <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= 1'b0;
      unique case (st_q)
        ST_FILL: begin
          if (frame_done_o) begin
            st_q   <= ST_FLUSH;
            cnt_q  <= '0;
            wbuf_q <= wbuf_ins;
          end else if (word_full) begin
            cnt_q  <= cnt_nx;
            wbuf_q <= '0;
            widx_q <= widx_q + 1'b1;
            we_q   <= 1'b1;
            addr_q <= {slot_q, widx_q};
            data_q <= wbuf_ins;
          end else if (take_byte) begin
            cnt_q  <= cnt_nx;
            wbuf_q <= wbuf_ins;
          end
        end
        ST_FLUSH: begin
          we_q   <= 1'b1;
          addr_q <= {slot_q, widx_q};
          if (widx_q != STAT_IDX) begin
            data_q <= wbuf_q;
            wbuf_q <= '0;
            widx_q <= widx_q + 1'b1;
          end else begin
            // status goes last, then move to the next slot
            data_q <= status_i;
            widx_q <= '0;
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
            st_q   <= ST_FILL;
          end
        end
        default: st_q <= ST_FILL;
      endcase
    end
  end

  assign mem_we_o   = we_q;
  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;

  a_r1_slot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[AW-1:WORD_W] <= LAST_SLOT));
  a_r2_word_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o) |-> mem_addr_o[WORD_W-1:0] == $past(mem_addr_o[WORD_W-1:0]) + 1'b1);
  a_r4_len_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_o <= LEN_W'(MAX_BYTES));
  a_r10_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i && st_q == ST_FILL |=> !mem_we_o);
endmodule

// File: rtl/rx_slot_packer.sv
module rx_slot_packer
  import rsp_pkg::*;
#(
  parameter int NBUF = 4,
  localparam int SLOT_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dma_en_i,
  input  logic                     irq_en_i,
  input  logic                     clr_i,
  input  logic                     byte_valid_i,
  input  logic [7:0]               byte_i,
  input  logic                     frame_end_i,
  input  logic                     crc_err_i,
  input  logic                     ovr_i,
  output logic                     mem_we_o,
  output logic [SLOT_W+WORD_W-1:0] mem_addr_o,
  output logic [31:0]              mem_data_o,
  output logic                     full_o,
  output logic                     crc_err_o,
  output logic                     ovr_o,
  output logic                     irq_o
);
  logic             accept, frame_done;
  logic [LEN_W-1:0] len;
  logic [31:0]      status;

  rsp_fill #(.NBUF(NBUF), .SLOT_W(SLOT_W)) u_fill (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dma_en_i     (dma_en_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .frame_end_i  (frame_end_i),
    .status_i     (status),
    .accept_o     (accept),
    .frame_done_o (frame_done),
    .len_o        (len),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_data_o   (mem_data_o)
  );

  rsp_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .frame_done_i (frame_done),
    .len_i        (len),
    .crc_err_i    (crc_err_i),
    .ovr_i        (ovr_i),
    .clr_i        (clr_i),
    .status_o     (status),
    .full_o       (full_o),
    .crc_o        (crc_err_o),
    .ovr_o        (ovr_o)
  );

  assign irq_o = full_o && irq_en_i;

  a_r11_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> full_o && irq_en_i);
  a_r13_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> !full_o && !crc_err_o && !ovr_o);
endmodule

// File: tb/rx_slot_packer_test.sv
`timescale 1ns/1ps
module rx_slot_packer_test;
  localparam int NBUF = 4;
  localparam int AW = $clog2(NBUF) + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_en = 1'b0, irq_en = 1'b0, clr = 1'b0;
  logic byte_valid = 1'b0, frame_end = 1'b0, crc_err = 1'b0, ovr = 1'b0;
  logic [7:0] byte_d = '0;
  logic mem_we, full, crc_f, ovr_f, irq;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_data;

  always #2.5 clk = ~clk;

  rx_slot_packer #(.NBUF(NBUF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en), .irq_en_i(irq_en), .clr_i(clr),
    .byte_valid_i(byte_valid), .byte_i(byte_d), .frame_end_i(frame_end),
    .crc_err_i(crc_err), .ovr_i(ovr), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .full_o(full), .crc_err_o(crc_f), .ovr_o(ovr_f), .irq_o(irq)
  );

  logic [31:0] mem [NBUF*8];
  int wr_cnt = 0;
  int last_addr = -1;
  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      mem[mem_addr] = mem_data;
      wr_cnt = wr_cnt + 1;
      last_addr = int'(mem_addr);
    end
  end

  int n_chk = 0, n_bad = 0;
  bit exp_full = 0, exp_crc = 0, exp_ovr = 0, carry = 0;
  int exp_slot = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    chk("R5 full flag", 32'(full), 32'(exp_full));
    chk("R6 crc flag", 32'(crc_f), 32'(exp_crc));
    chk("R7 ovr flag", 32'(ovr_f), 32'(exp_ovr));
    chk("R11 irq", 32'(irq), 32'(exp_full & irq_en));
  endtask

  task automatic clear_flags();
    clr = 1'b1;
    exp_full = 0; exp_crc = 0; exp_ovr = 0;
    step();
    clr = 1'b0;
  endtask

  // om: overrun with first byte; ol: overrun in end cycle; joint: last byte with end
  task automatic send_frame(int n, int base, bit crc, bit om, bit ol, bit joint, bit clr_end);
    logic [7:0] pb [28];
    int nb, w0, len;
    bit b25, b26;
    logic [31:0] st, ew;
    for (int i = 0; i < 28; i++) pb[i] = 8'h00;
    for (int i = 0; i < n && i < 28; i++) pb[i] = 8'(base + i);
    nb = joint ? n - 1 : n;
    w0 = wr_cnt;
    for (int i = 0; i < nb; i++) begin
      byte_valid = 1'b1; byte_d = 8'(base + i); ovr = om && (i == 0);
      step();
    end
    byte_valid = joint && (n > 0); byte_d = 8'(base + n - 1);
    frame_end = 1'b1; crc_err = crc; ovr = ol; clr = clr_end;
    if (dma_en) begin
      len = (n > 28) ? 28 : n;
      b25 = om || ol || (exp_full && !clr_end) || carry;
      b26 = crc || !om || ol || carry;
      st = {5'b0, b26, b25, crc, 8'(len), 16'h0};
      if (clr_end) begin exp_full = 0; exp_crc = 0; exp_ovr = 0; end
      exp_full |= b26; exp_crc |= crc; exp_ovr |= b25;
      carry = ol;
    end else st = '0;
    step();
    byte_valid = 0; frame_end = 0; crc_err = 0; ovr = 0; clr = 0;
    for (int i = 0; i < 10; i++) step();
    if (dma_en) begin
      chk("R2 write count", 32'(wr_cnt - w0), 32'd8);
      chk("R2 status last", 32'(last_addr), 32'(exp_slot*8 + 7));
      for (int w = 0; w < 7; w++) begin
        ew = {pb[4*w+3], pb[4*w+2], pb[4*w+1], pb[4*w]};
        chk("R2 payload", mem[exp_slot*8 + w], ew);
      end
      chk("R3 status word", mem[exp_slot*8 + 7], st);
      exp_slot = (exp_slot + 1) % NBUF;
    end else begin
      chk("R10 no write", 32'(wr_cnt - w0), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBUF*8; i++) mem[i] = 32'hdead_beef;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    chk("R13 no write after reset", 32'(mem_we), 32'd0);
    dma_en = 1; irq_en = 1;
    send_frame(5, 8'h10, 0, 0, 0, 0, 0);   // R1 slot 0, R5
    clear_flags();
    send_frame(28, 8'h40, 0, 0, 0, 1, 0);  // R4 exact, R2 joint byte
    clear_flags();
    send_frame(31, 8'h80, 0, 0, 0, 0, 0);  // R4 dropped bytes
    send_frame(3, 8'hc0, 0, 0, 0, 0, 0);   // R9 full still set
    clear_flags();
    send_frame(9, 8'h20, 1, 0, 0, 0, 0);   // R6, R1 wrap to slot 0
    irq_en = 0;
    step();                                 // R11 gated
    irq_en = 1;
    clear_flags();
    send_frame(6, 8'h30, 0, 1, 0, 0, 0);   // R7 mid-frame overrun
    clear_flags();
    send_frame(4, 8'h50, 0, 0, 1, 0, 0);   // R8 overrun at end
    clear_flags();
    send_frame(0, 8'h00, 0, 0, 0, 0, 0);   // R8 carried, empty frame
    dma_en = 0;
    send_frame(7, 8'h60, 1, 1, 1, 0, 0);   // R10 ignored
    dma_en = 1;
    send_frame(2, 8'h70, 0, 0, 0, 1, 1);   // R12 set wins, R10 pointer kept
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule